// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns one high-level flash request into the full run of bus cycles that a NAND device with an 8-bit multiplexed bus expects. A host gives an operation code, a linear byte address and a byte length. The sequencer sends the command bytes, the formatted address bytes and the data bytes to a lower-level bus cycle generator, one cycle at a time. After each confirm command it waits for the device's ready/busy line.

Read data leaves through a valid/ready byte stream, and program data enters through a second stream. Bus cycles stall whenever the stream partner is not ready. A linear address becomes a 2-byte column plus a 3-byte row (page) number, based on 2048-byte pages and 64-page blocks. A read or program that runs past the end of a page is split: the next page gets its own complete command and address sequence. Every accepted operation finishes with the device reset command.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy_o`, `done_o`, `cyc_req_o` and `rd_valid_o` are low and `req_ready_o` is high.
- R2: A page read (op code 2) issues cycles in this order: command 0x00, five address cycles, command 0x30, a ready wait, one read-data cycle per byte, and command 0xFF. Cycle type codes are 0 command, 1 address, 2 write data and 3 read data.
- R3: The five address bytes are, in order: column bits 7:0, the remaining column bits, then row bits 7:0, 15:8 and 23:16. The column is the address modulo 2048 and the row is the address divided by 2048.
- R4: A page program (op code 3) issues command 0x80, five address cycles, one write-data cycle per byte taken from the write stream in arrival order, command 0x10, a ready wait, and finally command 0xFF.
- R5: A block erase (op code 4) issues command 0x60, the three row bytes only, command 0xD0 and a ready wait. This group repeats with the row advanced by 64 for as long as the remaining length exceeds 131072 bytes, and then command 0xFF is sent.
- R6: The following requests are rejected: an erase whose address bits 16:0 are not all zero, a read, program or erase with zero length, and any op code above 4. A rejected request produces `done_o` and `err_o` together for one cycle, issues no bus cycle and never raises `busy_o`.
- R7: When a read or program moves past column 2047 with bytes still left, the transfer continues at column 0 of the next row with a complete new command and address sequence (for a program, only after the current page's 0x10 command and ready wait).
- R8: An ID read (op code 1) issues command 0x90, one address cycle of 0x00, five read-data cycles with no ready wait, and command 0xFF.
- R9: A reset request (op code 0) issues exactly one cycle, command 0xFF.
- R10: `busy_o` is high from acceptance until the final 0xFF cycle is acknowledged. `done_o` is then a one-cycle pulse with `busy_o` low and `err_o` low.
- R11: After a confirm command (0x30, 0x10, 0xD0), no bus cycle is requested until at least BUSY_GAP clocks have passed and `rb_i` is high.
- R12: A read-data cycle is never requested while a read byte is still waiting in the output stream. A write-data cycle is never requested while `wr_valid_i` is low. A byte held on the read stream stays stable until it is taken.
- R13: A bus cycle request keeps its type and byte stable from assertion until `cyc_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Operation request |
| req_ready_o | output | 1 | Sequencer idle, request taken |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | ADDR_W | Linear byte address |
| req_len_i | input | LEN_W | Byte length |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished pulse |
| err_o | output | 1 | Request rejected, with done_o |
| cyc_req_o | output | 1 | Bus cycle request |
| cyc_type_o | output | 2 | Cycle type: 0 cmd, 1 addr, 2 write, 3 read |
| cyc_byte_o | output | 8 | Command, address or write byte |
| cyc_ack_i | input | 1 | Bus cycle complete |
| cyc_rdata_i | input | 8 | Read byte, valid with cyc_ack_i on a read cycle |
| rb_i | input | 1 | Device ready (1) / busy (0) |
| wr_valid_i | input | 1 | Program byte available |
| wr_ready_o | output | 1 | Program byte taken |
| wr_data_i | input | 8 | Program byte |
| rd_valid_o | output | 1 | Read byte available |
| rd_ready_i | input | 1 | Read byte taken |
| rd_data_o | output | 8 | Read byte |

## Verification
The hardest situation to produce is a page split in the middle of a transfer while both stream partners are stalling. In that case the column wrap, the row increment and the reissued address bytes all have to line up with a stream that is back-pressured at random points. The stimulus starts reads and programs a few bytes before column 2047 and gates the read-ready and write-valid lines with different periodic patterns. It also holds a stream fully stalled for dozens of cycles in the middle of a page. Erase length is placed one byte over a block boundary so that the row advance by 64 happens exactly once.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_ID    = 3'd1,
    OP_READ  = 3'd2,
    OP_PROG  = 3'd3,
    OP_ERASE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    CY_CMD  = 2'd0,
    CY_ADDR = 2'd1,
    CY_WR   = 2'd2,
    CY_RD   = 2'd3
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD0, ST_ADDR, ST_WDATA, ST_CMD1, ST_WAIT, ST_RDATA, ST_RST
  } st_e;

  localparam logic [7:0] CMD_READ0  = 8'h00;
  localparam logic [7:0] CMD_READ1  = 8'h30;
  localparam logic [7:0] CMD_PROG0  = 8'h80;
  localparam logic [7:0] CMD_PROG1  = 8'h10;
  localparam logic [7:0] CMD_ERASE0 = 8'h60;
  localparam logic [7:0] CMD_ERASE1 = 8'hD0;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
endpackage

// File: rtl/nseq_addr_fmt.sv
module nseq_addr_fmt
  import nseq_pkg::*;
#(
  parameter int COL_W     = 11,
  parameter int ROW_BYTES = 3,
  localparam int ROW_W    = 8 * ROW_BYTES
) (
  input  logic [2:0]       op_i,
  input  logic [2:0]       idx_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [7:0]       byte_o,
  output logic             last_o
);
  logic [15:0] colx;
  logic [2:0]  n_bytes;
  logic [2:0]  ridx;

  assign colx = 16'(col_i);
  assign ridx = idx_i - 3'd2;

  always_comb begin
    if (op_i == OP_ID) begin
      byte_o  = 8'h00;
      n_bytes = 3'd1;
    end else if (op_i == OP_ERASE) begin
      byte_o  = 8'(row_i >> {idx_i, 3'b000});
      n_bytes = 3'(ROW_BYTES);
    end else begin
      // column bytes first, low then high, then row bytes low first
      byte_o  = (idx_i < 3'd2) ? 8'(colx >> {idx_i, 3'b000})
                               : 8'(row_i >> {ridx, 3'b000});
      n_bytes = 3'(2 + ROW_BYTES);
    end
  end

  assign last_o = (idx_i == n_bytes - 3'd1);
endmodule

// File: rtl/nseq_rb_wait.sv
module nseq_rb_wait #(
  parameter int GAP  = 4,
  localparam int CW  = $clog2(GAP + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rb_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(GAP);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (rb_i)   act_q <= 1'b0;
    end
  end

  assign done_o = act_q && (cnt_q == '0) && rb_i;

  a_r11_gap_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/nseq_rd_buf.sv
module nseq_rd_buf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r12_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 2048,
  parameter int BLK_PAGES  = 64,
  parameter int ROW_BYTES  = 3,
  parameter int BUSY_GAP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cyc_req_o,
  output logic [1:0]        cyc_type_o,
  output logic [7:0]        cyc_byte_o,
  input  logic              cyc_ack_i,
  input  logic [7:0]        cyc_rdata_i,
  input  logic              rb_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [7:0]        wr_data_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [7:0]        rd_data_o
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int BLKP_W = $clog2(BLK_PAGES);
  localparam int ROW_W  = 8 * ROW_BYTES;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(PAGE_BYTES - 1);
  localparam logic [LEN_W-1:0] BLK_LEN  = LEN_W'(PAGE_BYTES * BLK_PAGES);
  localparam logic [ROW_W-1:0] ROW_STEP = ROW_W'(BLK_PAGES);

  st_e              st_q;
  logic [2:0]       op_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] rem_q;
  logic [2:0]       idx_q;
  logic             cyc_req_q;
  cyc_e             cyc_type_q;
  logic [7:0]       cyc_byte_q;
  logic             done_q, err_q;

  logic       accept, bad_req, needs_len, misalign;
  logic       launch, ackd, page_end;
  cyc_e       l_type;
  logic [7:0] l_byte, cmd0, cmd1;
  logic [7:0] fmt_byte;
  logic       fmt_last;
  logic       wait_start, wait_done;

  assign accept    = (st_q == ST_IDLE) && req_valid_i;
  assign needs_len = (req_op_i == OP_READ) || (req_op_i == OP_PROG) || (req_op_i == OP_ERASE);
  assign misalign  = |req_addr_i[COL_W+BLKP_W-1:0];
  assign bad_req   = (req_op_i > 3'd4) || (needs_len && (req_len_i == '0)) ||
                     ((req_op_i == OP_ERASE) && misalign);
  assign ackd      = cyc_req_q && cyc_ack_i;
  assign page_end  = (col_q == COL_LAST);

  always_comb begin
    unique case (op_q)
      OP_ID:    cmd0 = CMD_ID;
      OP_READ:  cmd0 = CMD_READ0;
      OP_PROG:  cmd0 = CMD_PROG0;
      OP_ERASE: cmd0 = CMD_ERASE0;
      default:  cmd0 = CMD_RESET;
    endcase
    unique case (op_q)
      OP_READ: cmd1 = CMD_READ1;
      OP_PROG: cmd1 = CMD_PROG1;
      default: cmd1 = CMD_ERASE1;
    endcase
  end

  nseq_addr_fmt #(.COL_W(COL_W), .ROW_BYTES(ROW_BYTES)) u_fmt (
    .op_i   (op_q),
    .idx_i  (idx_q),
    .col_i  (col_q),
    .row_i  (row_q),
    .byte_o (fmt_byte),
    .last_o (fmt_last)
  );

  // cycle launch: only when no cycle is outstanding and the stream side allows it
  always_comb begin
    launch = 1'b0;
    l_type = CY_CMD;
    l_byte = 8'h00;
    unique case (st_q)
      ST_CMD0:  begin launch = !cyc_req_q; l_byte = cmd0; end
      ST_ADDR:  begin launch = !cyc_req_q; l_type = CY_ADDR; l_byte = fmt_byte; end
      ST_WDATA: begin launch = !cyc_req_q && wr_valid_i; l_type = CY_WR; l_byte = wr_data_i; end
      ST_CMD1:  begin launch = !cyc_req_q; l_byte = cmd1; end
      ST_RDATA: begin launch = !cyc_req_q && !rd_valid_o; l_type = CY_RD; end
      ST_RST:   begin launch = !cyc_req_q; l_byte = CMD_RESET; end
      default:  ;
    endcase
  end

  assign wait_start = (st_q == ST_CMD1) && ackd;

  nseq_rb_wait #(.GAP(BUSY_GAP)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wait_start),
    .rb_i    (rb_i),
    .done_o  (wait_done)
  );

  nseq_rd_buf u_rbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ackd && (cyc_type_q == CY_RD)),
    .data_i  (cyc_rdata_i),
    .ready_i (rd_ready_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      op_q       <= '0;
      col_q      <= '0;
      row_q      <= '0;
      rem_q      <= '0;
      idx_q      <= '0;
      cyc_req_q  <= 1'b0;
      cyc_type_q <= CY_CMD;
      cyc_byte_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad_req) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          op_q  <= req_op_i;
          col_q <= (req_op_i == OP_ID) ? '0 : req_addr_i[COL_W-1:0];
          row_q <= ROW_W'(req_addr_i >> COL_W);
          rem_q <= (req_op_i == OP_ID) ? LEN_W'(5) : req_len_i;
          st_q  <= (req_op_i == OP_RESET) ? ST_RST : ST_CMD0;
        end
      end
      if (launch) begin
        cyc_req_q  <= 1'b1;
        cyc_type_q <= l_type;
        cyc_byte_q <= l_byte;
      end else if (ackd) begin
        cyc_req_q <= 1'b0;
        unique case (st_q)
          ST_CMD0: begin
            st_q  <= ST_ADDR;
            idx_q <= '0;
          end
          ST_ADDR: begin
            idx_q <= idx_q + 3'd1;
            if (fmt_last)
              st_q <= (op_q == OP_ID)   ? ST_RDATA :
                      (op_q == OP_PROG) ? ST_WDATA : ST_CMD1;
          end
          ST_WDATA: begin
            rem_q <= rem_q - 1'b1;
            if (page_end) begin
              col_q <= '0;
              row_q <= row_q + 1'b1;
            end else begin
              col_q <= col_q + 1'b1;
            end
            if (rem_q == LEN_W'(1) || page_end) st_q <= ST_CMD1;
          end
          ST_CMD1: st_q <= ST_WAIT;
          ST_RDATA: begin
            rem_q <= rem_q - 1'b1;
            if (page_end) begin
              col_q <= '0;
              row_q <= row_q + 1'b1;
            end else begin
              col_q <= col_q + 1'b1;
            end
            if (rem_q == LEN_W'(1))                st_q <= ST_RST;
            else if (op_q != OP_ID && page_end)    st_q <= ST_CMD0;
          end
          ST_RST: begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
          default: ;
        endcase
      end
      if (st_q == ST_WAIT && wait_done) begin
        if (op_q == OP_READ) begin
          st_q <= ST_RDATA;
        end else if (op_q == OP_PROG) begin
          st_q <= (rem_q == '0) ? ST_RST : ST_CMD0;
        end else if (rem_q <= BLK_LEN) begin
          st_q <= ST_RST;
        end else begin
          rem_q <= rem_q - BLK_LEN;
          row_q <= row_q + ROW_STEP;
          st_q  <= ST_CMD0;
        end
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cyc_req_o   = cyc_req_q;
  assign cyc_type_o  = cyc_type_q;
  assign cyc_byte_o  = cyc_byte_q;
  assign wr_ready_o  = (st_q == ST_WDATA) && !cyc_req_q;

  a_r13_cycle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && !cyc_ack_i |=> cyc_req_o && $stable(cyc_byte_o) && $stable(cyc_type_o));
  a_r6_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && bad_req |=> done_o && err_o && !busy_o && !cyc_req_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !cyc_req_o);
  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r12_no_rd_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && cyc_type_o == 2'd3 |-> !rd_valid_o);
  a_r11_quiet_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT |-> !cyc_req_o);
endmodule

// File: tb/nand_op_seq_tb.sv
module nand_op_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_op;
  logic [31:0] req_addr;
  logic [19:0] req_len;
  logic        busy, done, err;
  logic        cyc_req;
  logic [1:0]  cyc_type;
  logic [7:0]  cyc_byte;
  logic        ack;
  logic [7:0]  rdat;
  logic        rb;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready;
  logic [7:0]  rd_data;

  always #10 clk = ~clk;

  nand_op_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .busy_o(busy), .done_o(done), .err_o(err),
    .cyc_req_o(cyc_req), .cyc_type_o(cyc_type), .cyc_byte_o(cyc_byte),
    .cyc_ack_i(ack), .cyc_rdata_i(rdat), .rb_i(rb),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus cycle responder / flash model
  logic [9:0] cyc_log [512];
  int         log_n;
  logic [7:0] rd_src;
  logic [9:0] first;
  int hold, rb_cnt, hold_viol, rb_viol, stall_viol;

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; rb = 1'b1; hold = 0; rb_cnt = 0; rdat = 8'h00;
      log_n = 0; rd_src = 8'h40; hold_viol = 0; rb_viol = 0; stall_viol = 0;
    end else begin
      if (cyc_req && !rb) rb_viol++;
      if (cyc_req && cyc_type == 2'd3 && rd_valid) stall_viol++;
      if (ack) ack = 1'b0;
      else if (cyc_req) begin
        if (hold == 0) first = {cyc_type, cyc_byte};
        else if (first != {cyc_type, cyc_byte}) hold_viol++;
        hold++;
        if (hold == 2) begin
          hold = 0;
          ack  = 1'b1;
          if (cyc_type == 2'd3) begin
            rdat = rd_src;
            cyc_log[log_n] = {2'd3, rd_src};
            rd_src++;
          end else begin
            cyc_log[log_n] = {cyc_type, cyc_byte};
          end
          log_n++;
          if (cyc_type == 2'd0 && (cyc_byte == 8'h30 || cyc_byte == 8'h10 || cyc_byte == 8'hD0)) begin
            rb = 1'b0;
            rb_cnt = 10;
          end
        end
      end
      if (rb_cnt > 0) begin
        rb_cnt--;
        if (rb_cnt == 0) rb = 1'b1;
      end
    end
  end

  // read stream consumer
  logic       rd_hold = 1'b0;
  logic [7:0] rx [512];
  int         rx_n = 0;
  int         tk_r = 0;
  always @(negedge clk) begin
    tk_r++;
    rd_ready = rst_n && !rd_hold && (tk_r % 3 != 0);
    #1;
    if (rd_valid && rd_ready) begin
      rx[rx_n] = rd_data;
      rx_n++;
    end
  end

  // program stream producer
  logic wr_hold = 1'b0;
  int   wr_n = 0;
  int   tk_w = 0;
  always @(negedge clk) begin
    tk_w++;
    wr_valid = rst_n && !wr_hold && (tk_w % 4 != 1);
    wr_data  = 8'(wr_n * 7 + 3);
    #1;
    if (wr_valid && wr_ready) wr_n++;
  end

  int busy_n = 0;
  always @(negedge clk) if (busy) busy_n++;

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end
  end

  // expected cycle list
  logic [9:0] exp_q [128];
  int exp_n, exp_rd;
  int log0, rx0, wr0, bz0;
  logic [7:0] src0;

  task automatic push(input logic [1:0] t, input logic [7:0] b);
    exp_q[exp_n] = {t, b};
    exp_n++;
  endtask

  task automatic build_exp(input logic [2:0] op, input logic [31:0] addr, input int len);
    int col, row, rem, k, w;
    exp_n = 0; exp_rd = 0; w = 0;
    col = int'(addr % 2048); row = int'(addr / 2048); rem = len;
    case (op)
      3'd0: push(0, 8'hFF);
      3'd1: begin
        push(0, 8'h90); push(1, 8'h00);
        for (k = 0; k < 5; k++) begin push(3, 8'(src0 + k)); exp_rd++; end
        push(0, 8'hFF);
      end
      3'd2, 3'd3: begin
        while (rem > 0) begin
          push(0, (op == 3'd2) ? 8'h00 : 8'h80);
          push(1, 8'(col)); push(1, 8'(col >> 8));
          push(1, 8'(row)); push(1, 8'(row >> 8)); push(1, 8'(row >> 16));
          if (op == 3'd2) push(0, 8'h30);
          while (rem > 0 && col < 2048) begin
            if (op == 3'd2) begin push(3, 8'(src0 + exp_rd)); exp_rd++; end
            else begin push(2, 8'((wr0 + w) * 7 + 3)); w++; end
            col++; rem--;
          end
          if (op == 3'd3) push(0, 8'h10);
          col = 0; row++;
        end
        push(0, 8'hFF);
      end
      3'd4: begin
        forever begin
          push(0, 8'h60);
          push(1, 8'(row)); push(1, 8'(row >> 8)); push(1, 8'(row >> 16));
          push(0, 8'hD0);
          if (rem <= 131072) break;
          rem -= 131072; row += 64;
        end
        push(0, 8'hFF);
      end
      default: ;
    endcase
  endtask

  task automatic start_op(input logic [2:0] op, input logic [31:0] addr, input logic [19:0] len);
    @(negedge clk);
    log0 = log_n; rx0 = rx_n; wr0 = wr_n; src0 = rd_src; bz0 = busy_n;
    req_op = op; req_addr = addr; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit e, output bit got);
    got = 0; e = 0;
    for (int k = 0; k < 4000; k++) begin
      if (done) begin got = 1; e = err; break; end
      @(negedge clk);
    end
    for (int k = 0; k < 30 && rd_valid; k++) @(negedge clk);
  endtask

  task automatic cmp_seq(input string tag);
    int bad;
    bad = -1;
    chk(log_n - log0 == exp_n, {tag, " cycle count"}, log_n - log0, exp_n);
    for (int i = 0; i < exp_n && i < log_n - log0; i++)
      if (bad < 0 && cyc_log[log0 + i] != exp_q[i]) bad = i;
    chk(bad < 0, {tag, " cycle sequence"}, (bad < 0) ? 0 : cyc_log[log0 + bad],
        (bad < 0) ? 0 : exp_q[bad]);
  endtask

  task automatic cmp_rx(input string tag);
    int bad;
    bad = -1;
    chk(rx_n - rx0 == exp_rd, {tag, " read stream count"}, rx_n - rx0, exp_rd);
    for (int i = 0; i < exp_rd && i < rx_n - rx0; i++)
      if (bad < 0 && rx[rx0 + i] != 8'(src0 + i)) bad = i;
    chk(bad < 0, {tag, " read stream data"}, (bad < 0) ? 0 : rx[rx0 + bad],
        (bad < 0) ? 0 : 8'(src0 + bad));
  endtask

  // {op[3], addr[32], len[20], err[1], tag[4]}
  localparam int NV = 12;
  localparam logic [59:0] VEC [NV] = '{
    {3'd0, 32'h0000_0000, 20'd0,     1'b0, 4'd9},  // R9 reset op
    {3'd1, 32'h0000_0000, 20'd0,     1'b0, 4'd8},  // R8 ID read
    {3'd2, 32'h0000_1803, 20'd2,     1'b0, 4'd2},  // R2 page read
    {3'd2, 32'h091A_2FF0, 20'd3,     1'b0, 4'd3},  // R3 wide row address
    {3'd2, 32'h0000_0FFE, 20'd5,     1'b0, 4'd7},  // R7 read crosses page
    {3'd3, 32'h0000_5000, 20'd4,     1'b0, 4'd4},  // R4 program
    {3'd3, 32'h0000_27FF, 20'd3,     1'b0, 4'd7},  // R7 program crosses page
    {3'd4, 32'h0004_0000, 20'h20001, 1'b0, 4'd5},  // R5 two-block erase
    {3'd4, 32'h0002_0000, 20'h20000, 1'b0, 4'd5},  // R5 exactly one block
    {3'd4, 32'h0000_0800, 20'd1,     1'b1, 4'd6},  // R6 misaligned erase
    {3'd2, 32'h0000_0100, 20'd0,     1'b1, 4'd6},  // R6 zero length
    {3'd7, 32'h0000_0000, 20'd4,     1'b1, 4'd6}   // R6 bad op code
  };

  initial begin
    bit e, got;
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !cyc_req && !rd_valid, "R1 idle outputs", {busy, done, cyc_req, rd_valid}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    for (int v = 0; v < NV; v++) begin
      logic [2:0]  op;
      logic [31:0] ad;
      logic [19:0] ln;
      logic        xe;
      string       tag;
      op = VEC[v][59:57]; ad = VEC[v][56:25]; ln = VEC[v][24:5]; xe = VEC[v][4];
      tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
      start_op(op, ad, ln);
      src0 = rd_src;
      build_exp(op, ad, int'(ln));
      if (xe) exp_n = 0;
      wait_done(e, got);
      chk(got, {tag, " done seen"}, got, 1);
      chk(e == xe, {tag, " error flag"}, e, xe);
      cmp_seq(tag);
      if (op == 3'd1 || op == 3'd2) cmp_rx(tag);
      // R10 busy during accepted ops, R6 never busy on reject
      if (xe) chk(busy_n == bz0, "R6 no busy on reject", busy_n - bz0, 0);
      else    chk(busy_n > bz0, "R10 busy seen", busy_n - bz0, 1);
      @(negedge clk);
      chk(!done && !busy, "R10 done single pulse", {done, busy}, 0);
    end

    // R12 read stall: consumer held off, only one read cycle may run
    rd_hold = 1'b1;
    start_op(3'd2, 32'h0000_0800, 20'd3);
    src0 = rd_src;
    build_exp(3'd2, 32'h0000_0800, 3);
    repeat (60) @(negedge clk);
    n = 0;
    for (int i = log0; i < log_n; i++) if (cyc_log[i][9:8] == 2'd3) n++;
    chk(n == 1, "R12 read cycles while stalled", n, 1);
    chk(rd_valid && busy, "R12 byte waiting", {rd_valid, busy}, 2'b11);
    rd_hold = 1'b0;
    wait_done(e, got);
    cmp_seq("R12 stalled read");
    cmp_rx("R12 stalled read");

    // R12 write stall: no write-data cycle without a valid byte
    wr_hold = 1'b1;
    start_op(3'd3, 32'h0000_1000, 20'd2);
    build_exp(3'd3, 32'h0000_1000, 2);
    repeat (60) @(negedge clk);
    n = 0;
    for (int i = log0; i < log_n; i++) if (cyc_log[i][9:8] == 2'd2) n++;
    chk(n == 0, "R12 write cycles while starved", n, 0);
    chk(log_n - log0 == 6, "R12 address phase complete", log_n - log0, 6);
    wr_hold = 1'b0;
    wait_done(e, got);
    cmp_seq("R12 starved program");

    chk(rb_viol == 0, "R11 cycle while device busy", rb_viol, 0);
    chk(hold_viol == 0, "R13 request changed before ack", hold_viol, 0);
    chk(stall_viol == 0, "R12 read cycle over full buffer", stall_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule